// File: doc/BRIEF.md
# Ring-Buffer Stream DMA with Software Fetch Limit

This block is a single-channel read DMA. It moves the contents of a ring buffer held in host memory onto a byte-wide valid/ready stream. The ring is described by a circular table of four-word buffer descriptors in memory. The engine reads one descriptor, then that buffer's data words, and sends the bytes out one per beat. It then moves on to the next table entry, returning to entry 0 after the last valid index. A link position counter follows every byte delivered and folds back to zero at the programmed ring length.

Software can turn on a fetch limit. While the link position equals the programmed limit offset, the engine issues no data read and delivers no byte. Software therefore refills the part of the ring behind the limit and then moves the limit forward to let the transfer continue. Memory is reached through a one-outstanding request/grant/response read port. Status bits report completed buffers and descriptor faults, and a level interrupt is raised for each status bit whose enable is set.

Top module: `ring_dma_stream`

## Requirements
- R1: While and after reset, out_valid, mem_req and irq are low, and the link position, status and control registers read as zero.
- R2: Descriptor i is read from list_base + 16*i. Word 0 holds the buffer address bits 31:0, word 1 holds the address bits 63:32, word 2 holds the byte length and word 3 holds flags that are ignored. list_base is made of the high base register and bits 31:7 of the low base register, with bits 6:0 zero. The buffer's bytes leave in ascending address order, byte k of a 32-bit word coming from bits 8k+7:8k, and buffers start on 4-byte boundaries.
- R3: After the descriptor whose index equals the last-index register, the engine continues with descriptor 0.
- R4: The link position (offset 2) rises by one for each byte accepted (out_valid and out_ready) and changes at no other time. It returns to 0 when it would reach the ring length (offset 3).
- R5: When limit control bit 0 (offset 7) is 1 and the link position equals the limit offset (offset 8), no byte is delivered and no data word is read. Writing a new limit offset lets delivery continue up to it.
- R6: When limit control bit 0 is 0, the limit offset has no effect on delivery.
- R7: With control bit 1 (run) at 0, no new memory request is issued. Setting it again continues from the stopped position, with no byte lost or repeated.
- R8: Status bit 2 is set when the last byte of a buffer is accepted.
- R9: A descriptor with length 0, or a read response with mem_rerr high, sets status bit 4 and clears control bit 1.
- R10: Writing 1 to status bits 2, 3 or 4 (offset 1) clears that bit. Writing 0 leaves it unchanged.
- R11: irq is high when any of status bits 2, 3 or 4 is set together with the control bit in the same position (control bits 2, 3, 4 are the enables).
- R12: While control bit 0 (stream reset) is 1, the link position, the descriptor index and the status are cleared, and the engine stays idle.
- R13: The registers are at word offsets 0 control (stream number in bits 23:20), 1 status, 2 link position, 3 ring length, 4 last index, 5 low list base (bit 0 protect, read back), 6 high list base, 7 limit control, 8 limit offset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 4 | Register word offset |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data for reg_addr, combinational |
| irq | output | 1 | Interrupt request, level |
| mem_req | output | 1 | Read request valid |
| mem_addr | output | ADDR_W | Read byte address, 4-byte aligned |
| mem_gnt | input | 1 | Request accepted this cycle |
| mem_rvalid | input | 1 | Read response valid |
| mem_rdata | input | 32 | Read response word |
| mem_rerr | input | 1 | Read response carries an error |
| out_valid | output | 1 | Output byte valid |
| out_data | output | 8 | Output byte |
| out_ready | input | 1 | Downstream accepts the byte |

## Verification
The bench builds the block with ADDR_W at 40. This keeps the upper list-base and buffer-address words meaningful while truncating them, and it places one buffer above 4 GiB. The ring is three descriptors of 8, 5 and 12 bytes in a 25-byte ring. With that short a ring, random limit steps cross the position wrap and the descriptor-index wrap many times within a few hundred bytes. Random grant, response latency and out_ready stretch every state of the fetch sequence. Directed runs then cover the stop with the limit disabled, a run pause and resume, a zero-length descriptor and an error response in the middle of a buffer.

// File: rtl/ring_dma_pkg.sv
package ring_dma_pkg;

   localparam int REG_AW = 4;

   localparam logic [REG_AW-1:0] OFS_CTRL   = 4'd0;
   localparam logic [REG_AW-1:0] OFS_STAT   = 4'd1;
   localparam logic [REG_AW-1:0] OFS_LPOS   = 4'd2;
   localparam logic [REG_AW-1:0] OFS_RLEN   = 4'd3;
   localparam logic [REG_AW-1:0] OFS_LAST   = 4'd4;
   localparam logic [REG_AW-1:0] OFS_BASELO = 4'd5;
   localparam logic [REG_AW-1:0] OFS_BASEHI = 4'd6;
   localparam logic [REG_AW-1:0] OFS_LIMCTL = 4'd7;
   localparam logic [REG_AW-1:0] OFS_LIMPOS = 4'd8;

   localparam int CTL_SRST    = 0;
   localparam int CTL_RUN     = 1;
   localparam int EVT_LSB     = 2;   // completion / fifo / descriptor, shared by enables and status
   localparam int EVT_MSB     = 4;
   localparam int CTL_STM_LSB = 20;
   localparam int STM_W       = 4;
   localparam int BASE_ALIGN  = 7;

   typedef enum logic [2:0] {
      ST_DESC,
      ST_DWAIT,
      ST_DATA,
      ST_FWAIT,
      ST_EMIT,
      ST_HALT
   } eng_state_t;

endpackage

// File: rtl/ring_dma_regs.sv
module ring_dma_regs
   import ring_dma_pkg::*;
#(
   parameter int ADDR_W = 64,
   parameter int IDX_W  = 8,
   parameter int POS_W  = 32
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              reg_we,
   input  logic [REG_AW-1:0] reg_addr,
   input  logic [31:0]       reg_wdata,
   output logic [31:0]       reg_rdata,
   output logic              irq,
   output logic              srst,
   output logic              run,
   output logic [POS_W-1:0]  ring_len,
   output logic [IDX_W-1:0]  last_idx,
   output logic [ADDR_W-1:0] list_base,
   output logic              lim_en,
   output logic [POS_W-1:0]  lim_pos,
   input  logic [POS_W-1:0]  lpos,
   input  logic              set_done,
   input  logic              set_derr
);

   localparam int EVT_N = EVT_MSB - EVT_LSB + 1;

   logic             ctl_srst, ctl_run;
   logic [EVT_N-1:0] ctl_ie, stat_q;
   logic [STM_W-1:0] ctl_stm;
   logic [POS_W-1:0] rlen_q, limpos_q;
   logic [IDX_W-1:0] last_q;
   logic [31:BASE_ALIGN] baselo_q;
   logic             prot_q;
   logic [31:0]      basehi_q;
   logic             limen_q;
   logic [63:0]      base_full;
   logic [EVT_N-1:0] w1c, set_vec;

   assign w1c     = (reg_we && reg_addr == OFS_STAT) ? reg_wdata[EVT_MSB:EVT_LSB] : '0;
   assign set_vec = {set_derr, 1'b0, set_done};

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ctl_srst <= 1'b0;
         ctl_run  <= 1'b0;
         ctl_ie   <= '0;
         ctl_stm  <= '0;
         stat_q   <= '0;
         rlen_q   <= '0;
         last_q   <= '0;
         baselo_q <= '0;
         prot_q   <= 1'b0;
         basehi_q <= '0;
         limen_q  <= 1'b0;
         limpos_q <= '0;
      end else begin
         if (reg_we) begin
            unique case (reg_addr)
               OFS_CTRL: begin
                  ctl_srst <= reg_wdata[CTL_SRST];
                  ctl_run  <= reg_wdata[CTL_RUN];
                  ctl_ie   <= reg_wdata[EVT_MSB:EVT_LSB];
                  ctl_stm  <= reg_wdata[CTL_STM_LSB +: STM_W];
               end
               OFS_RLEN:   rlen_q   <= reg_wdata[POS_W-1:0];
               OFS_LAST:   last_q   <= reg_wdata[IDX_W-1:0];
               OFS_BASELO: begin
                  baselo_q <= reg_wdata[31:BASE_ALIGN];
                  prot_q   <= reg_wdata[0];
               end
               OFS_BASEHI: basehi_q <= reg_wdata;
               OFS_LIMCTL: limen_q  <= reg_wdata[0];
               OFS_LIMPOS: limpos_q <= reg_wdata[POS_W-1:0];
               default: ;
            endcase
         end
         if (set_derr) ctl_run <= 1'b0;
         if (ctl_srst) stat_q <= '0;
         else          stat_q <= (stat_q & ~w1c) | set_vec;
      end
   end

   assign base_full = {basehi_q, baselo_q, {BASE_ALIGN{1'b0}}};
   assign list_base = base_full[ADDR_W-1:0];
   assign srst      = ctl_srst;
   assign run       = ctl_run;
   assign ring_len  = rlen_q;
   assign last_idx  = last_q;
   assign lim_en    = limen_q;
   assign lim_pos   = limpos_q;
   assign irq       = |(stat_q & ctl_ie);

   always_comb begin
      reg_rdata = '0;
      unique case (reg_addr)
         OFS_CTRL: begin
            reg_rdata[CTL_SRST]                = ctl_srst;
            reg_rdata[CTL_RUN]                 = ctl_run;
            reg_rdata[EVT_MSB:EVT_LSB]         = ctl_ie;
            reg_rdata[CTL_STM_LSB +: STM_W]    = ctl_stm;
         end
         OFS_STAT:   reg_rdata[EVT_MSB:EVT_LSB] = stat_q;
         OFS_LPOS:   reg_rdata = 32'(lpos);
         OFS_RLEN:   reg_rdata = 32'(rlen_q);
         OFS_LAST:   reg_rdata = 32'(last_q);
         OFS_BASELO: begin
            reg_rdata[31:BASE_ALIGN] = baselo_q;
            reg_rdata[0]             = prot_q;
         end
         OFS_BASEHI: reg_rdata = basehi_q;
         OFS_LIMCTL: reg_rdata[0] = limen_q;
         OFS_LIMPOS: reg_rdata = 32'(limpos_q);
         default: ;
      endcase
   end

   // R9
   derr_stop_chk: assert property (@(posedge clk) disable iff (!rst_n)
      set_derr |=> !ctl_run);

   // R10
   w1c_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (reg_we && reg_addr == OFS_STAT && reg_wdata[EVT_MSB] && !set_derr) |=> !stat_q[EVT_N-1]);

   // R8
   done_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (set_done && !ctl_srst) |=> stat_q[0]);

endmodule

// File: rtl/ring_dma_engine.sv
module ring_dma_engine
   import ring_dma_pkg::*;
#(
   parameter int ADDR_W     = 64,
   parameter int IDX_W      = 8,
   parameter int POS_W      = 32,
   parameter int MEM_W      = 32,
   parameter bit LIMIT_IMPL = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              srst,
   input  logic              run,
   input  logic [POS_W-1:0]  ring_len,
   input  logic [IDX_W-1:0]  last_idx,
   input  logic [ADDR_W-1:0] list_base,
   input  logic              lim_en,
   input  logic [POS_W-1:0]  lim_pos,
   output logic [POS_W-1:0]  lpos,
   output logic              set_done,
   output logic              set_derr,
   output logic              mem_req,
   output logic [ADDR_W-1:0] mem_addr,
   input  logic              mem_gnt,
   input  logic              mem_rvalid,
   input  logic [MEM_W-1:0]  mem_rdata,
   input  logic              mem_rerr,
   output logic              out_valid,
   output logic [7:0]        out_data,
   output logic              out_ready_unused_n,
   input  logic              out_ready
);

   localparam int BYTES  = MEM_W / 8;
   localparam int LANE_W = $clog2(BYTES);
   localparam int LEN_W  = MEM_W;
   localparam int DW_N   = 4;
   localparam int DW_W   = $clog2(DW_N);

   eng_state_t        st;
   logic [IDX_W-1:0]  idx;
   logic [DW_W-1:0]   dw;
   logic [MEM_W-1:0]  d_lo, d_hi, word_q;
   logic [LEN_W-1:0]  d_len, d_off;
   logic [63:0]       d_full;
   logic [ADDR_W-1:0] desc_addr, data_addr;
   logic [LANE_W-1:0] lane;
   logic [7:0]        lanes [BYTES];
   logic              at_limit, beat, last_byte;
   logic [POS_W-1:0]  lpos_inc, lpos_nxt;

   generate
      if (LIMIT_IMPL) begin : g_limit
         assign at_limit = lim_en && (lpos == lim_pos);
         // R5
         limit_hold_chk: assert property (@(posedge clk) disable iff (!rst_n || srst)
            (lim_en && lpos == lim_pos) |=> $stable(lpos));
      end else begin : g_nolimit
         logic unused_lim;
         assign unused_lim = ^{lim_en, lim_pos};
         assign at_limit   = 1'b0;
      end
      for (genvar g = 0; g < BYTES; g++) begin : g_lane
         assign lanes[g] = word_q[8*g +: 8];
      end
   endgenerate

   assign d_full    = {d_hi, d_lo};
   assign desc_addr = list_base + ADDR_W'({idx, dw, 2'b00});
   assign data_addr = d_full[ADDR_W-1:0] + ADDR_W'({d_off[LEN_W-1:LANE_W], {LANE_W{1'b0}}});
   assign lane      = d_off[LANE_W-1:0];
   assign out_data  = lanes[lane];

   assign out_valid = !srst && st == ST_EMIT && !at_limit;
   assign mem_req   = !srst && run &&
                      (st == ST_DESC || (st == ST_DATA && !at_limit));
   assign mem_addr  = (st == ST_DESC) ? desc_addr : data_addr;
   assign out_ready_unused_n = 1'b0;

   assign beat      = out_valid && out_ready;
   assign last_byte = (d_off + 1'b1) == d_len;
   assign lpos_inc  = lpos + 1'b1;
   assign lpos_nxt  = (lpos_inc == ring_len) ? '0 : lpos_inc;

   assign set_done  = beat && last_byte;
   assign set_derr  = !srst && mem_rvalid &&
                      ((st == ST_DWAIT && (mem_rerr || (dw == DW_W'(DW_N-1) && d_len == '0))) ||
                       (st == ST_FWAIT && mem_rerr));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st     <= ST_DESC;
         idx    <= '0;
         dw     <= '0;
         d_lo   <= '0;
         d_hi   <= '0;
         d_len  <= '0;
         d_off  <= '0;
         word_q <= '0;
         lpos   <= '0;
      end else if (srst) begin
         st    <= ST_DESC;
         idx   <= '0;
         dw    <= '0;
         d_off <= '0;
         lpos  <= '0;
      end else begin
         unique case (st)
            ST_DESC:  if (mem_req && mem_gnt) st <= ST_DWAIT;
            ST_DWAIT: if (mem_rvalid) begin
               if (set_derr) begin
                  dw <= '0;
                  st <= ST_HALT;
               end else begin
                  unique case (dw)
                     2'd0:    d_lo  <= mem_rdata;
                     2'd1:    d_hi  <= mem_rdata;
                     2'd2:    d_len <= mem_rdata;
                     default: ;
                  endcase
                  if (dw == DW_W'(DW_N-1)) begin
                     d_off <= '0;
                     st    <= ST_DATA;
                  end else begin
                     dw <= dw + 1'b1;
                     st <= ST_DESC;
                  end
               end
            end
            ST_DATA:  if (mem_req && mem_gnt) st <= ST_FWAIT;
            ST_FWAIT: if (mem_rvalid) begin
               if (mem_rerr) begin
                  dw <= '0;
                  st <= ST_HALT;
               end else begin
                  word_q <= mem_rdata;
                  st     <= ST_EMIT;
               end
            end
            ST_EMIT:  if (beat) begin
               lpos  <= lpos_nxt;
               d_off <= d_off + 1'b1;
               if (last_byte) begin
                  idx <= (idx == last_idx) ? '0 : idx + 1'b1;
                  dw  <= '0;
                  st  <= ST_DESC;
               end else if (&lane) begin
                  st <= ST_DATA;
               end
            end
            ST_HALT:  if (!run) st <= ST_DESC;
            default:  st <= ST_DESC;
         endcase
      end
   end

   // R4
   lpos_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!srst && !(out_valid && out_ready)) |=> lpos == $past(lpos));

   // R12
   srst_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
      srst |=> (lpos == '0 && !out_valid));

endmodule

// File: rtl/ring_dma_stream.sv
module ring_dma_stream
   import ring_dma_pkg::*;
#(
   parameter int ADDR_W     = 64,
   parameter int IDX_W      = 8,
   parameter int POS_W      = 32,
   parameter bit LIMIT_IMPL = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              reg_we,
   input  logic [3:0]        reg_addr,
   input  logic [31:0]       reg_wdata,
   output logic [31:0]       reg_rdata,
   output logic              irq,
   output logic              mem_req,
   output logic [ADDR_W-1:0] mem_addr,
   input  logic              mem_gnt,
   input  logic              mem_rvalid,
   input  logic [31:0]       mem_rdata,
   input  logic              mem_rerr,
   output logic              out_valid,
   output logic [7:0]        out_data,
   input  logic              out_ready
);

   localparam int MEM_W = 32;

   generate
      if (ADDR_W < 33 || ADDR_W > 64) begin : g_bad_addr
         $error("ring_dma_stream: ADDR_W must lie in 33..64");
      end
      if (IDX_W < 1 || IDX_W > 8) begin : g_bad_idx
         $error("ring_dma_stream: IDX_W must lie in 1..8");
      end
      if (POS_W < 2 || POS_W > 32) begin : g_bad_pos
         $error("ring_dma_stream: POS_W must lie in 2..32");
      end
   endgenerate

   logic              srst_w, run_w, lim_en_w, set_done_w, set_derr_w;
   logic [POS_W-1:0]  ring_len_w, lim_pos_w, lpos_w;
   logic [IDX_W-1:0]  last_idx_w;
   logic [ADDR_W-1:0] list_base_w;
   logic              unused_tie;

   ring_dma_regs #(
      .ADDR_W (ADDR_W),
      .IDX_W  (IDX_W),
      .POS_W  (POS_W)
   ) regs_i (
      .clk       (clk),
      .rst_n     (rst_n),
      .reg_we    (reg_we),
      .reg_addr  (reg_addr),
      .reg_wdata (reg_wdata),
      .reg_rdata (reg_rdata),
      .irq       (irq),
      .srst      (srst_w),
      .run       (run_w),
      .ring_len  (ring_len_w),
      .last_idx  (last_idx_w),
      .list_base (list_base_w),
      .lim_en    (lim_en_w),
      .lim_pos   (lim_pos_w),
      .lpos      (lpos_w),
      .set_done  (set_done_w),
      .set_derr  (set_derr_w)
   );

   ring_dma_engine #(
      .ADDR_W     (ADDR_W),
      .IDX_W      (IDX_W),
      .POS_W      (POS_W),
      .MEM_W      (MEM_W),
      .LIMIT_IMPL (LIMIT_IMPL)
   ) eng_i (
      .clk                (clk),
      .rst_n              (rst_n),
      .srst               (srst_w),
      .run                (run_w),
      .ring_len           (ring_len_w),
      .last_idx           (last_idx_w),
      .list_base          (list_base_w),
      .lim_en             (lim_en_w),
      .lim_pos            (lim_pos_w),
      .lpos               (lpos_w),
      .set_done           (set_done_w),
      .set_derr           (set_derr_w),
      .mem_req            (mem_req),
      .mem_addr           (mem_addr),
      .mem_gnt            (mem_gnt),
      .mem_rvalid         (mem_rvalid),
      .mem_rdata          (mem_rdata),
      .mem_rerr           (mem_rerr),
      .out_valid          (out_valid),
      .out_data           (out_data),
      .out_ready_unused_n (unused_tie),
      .out_ready          (out_ready)
   );

   // R7
   halt_no_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !run_w |-> !mem_req);

endmodule

// File: tb/ring_dma_stream_tb_top.sv
`timescale 1ns/1ps
module ring_dma_stream_tb_top;

   localparam int AW = 40;
   localparam logic [AW-1:0] LBASE = 40'h01_0000_0080;

   logic          clk = 1'b0;
   logic          rst_n;
   logic          reg_we;
   logic [3:0]    reg_addr;
   logic [31:0]   reg_wdata, reg_rdata;
   logic          irq;
   logic          mem_req;
   logic [AW-1:0] mem_addr;
   logic          mem_gnt, mem_rvalid, mem_rerr;
   logic [31:0]   mem_rdata;
   logic          out_valid, out_ready;
   logic [7:0]    out_data;

   int unsigned vec = 0, bad = 0, nbytes = 0, req_seen = 0;
   logic [31:0]   dlen [3];
   logic [AW-1:0] dbuf [3];
   logic [AW-1:0] err_addr;
   logic          pend;
   logic [AW-1:0] paddr;
   int unsigned   dly;

   always #10 clk = ~clk;

   ring_dma_stream #(.ADDR_W(AW)) dut_i (
      .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
      .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .irq(irq),
      .mem_req(mem_req), .mem_addr(mem_addr), .mem_gnt(mem_gnt),
      .mem_rvalid(mem_rvalid), .mem_rdata(mem_rdata), .mem_rerr(mem_rerr),
      .out_valid(out_valid), .out_data(out_data), .out_ready(out_ready)
   );

   function automatic logic [31:0] dataword(input logic [AW-1:0] a);
      return (a[31:0] * 32'h9E37_79B1) ^ {24'h0, a[39:32]} ^ 32'h5A5A_0000;
   endfunction

   function automatic logic [31:0] memword(input logic [AW-1:0] a);
      if (a >= LBASE && a < LBASE + 48) begin
         int i = int'((a - LBASE) >> 2);
         int k = i / 4;
         case (i % 4)
            0: return dbuf[k][31:0];
            1: return 32'(dbuf[k][AW-1:32]);
            2: return dlen[k];
            default: return 32'hFFFF_0000;
         endcase
      end
      return dataword({a[AW-1:2], 2'b00});
   endfunction

   function automatic logic [7:0] exp_byte(input int unsigned n);
      int unsigned total = dlen[0] + dlen[1] + dlen[2];
      int unsigned p = n % total;
      int k = 0;
      logic [AW-1:0] a;
      logic [31:0] w;
      while (p >= dlen[k]) begin
         p -= dlen[k];
         k++;
      end
      a = dbuf[k] + AW'(p);
      w = dataword({a[AW-1:2], 2'b00});
      return w[8*a[1:0] +: 8];
   endfunction

   task automatic check(input bit ok, input string req, input string what,
                        input logic [63:0] act, input logic [63:0] exp);
      vec++;
      if (!ok) begin
         bad++;
         $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
      end
   endtask

   // memory responder, one outstanding read, random grant and latency
   always @(posedge clk) begin
      mem_rvalid <= 1'b0;
      if (pend) begin
         if (dly == 0) begin
            mem_rvalid <= 1'b1;
            mem_rdata  <= memword(paddr);
            mem_rerr   <= (paddr == err_addr);
            pend       <= 1'b0;
         end else begin
            dly <= dly - 1;
         end
      end else if (mem_req && mem_gnt) begin
         pend  <= 1'b1;
         paddr <= mem_addr;
         dly   <= $urandom_range(0, 2);
      end
      mem_gnt   <= ($urandom_range(0, 2) != 0);
      out_ready <= ($urandom_range(0, 3) != 0);
   end

   // stream monitor
   always @(negedge clk) begin
      if (rst_n && mem_req) req_seen++;
      if (rst_n && out_valid && out_ready) begin
         check(out_data == exp_byte(nbytes), (nbytes >= 25) ? "R3" : "R2",
               $sformatf("byte %0d", nbytes), 64'(out_data), 64'(exp_byte(nbytes)));
         nbytes++;
      end
   end

   task automatic reg_wr(input logic [3:0] a, input logic [31:0] d);
      @(negedge clk);
      reg_we = 1'b1; reg_addr = a; reg_wdata = d;
      @(negedge clk);
      reg_we = 1'b0;
   endtask

   task automatic reg_rd(input logic [3:0] a, output logic [31:0] d);
      @(negedge clk);
      reg_addr = a;
      #1 d = reg_rdata;
   endtask

   task automatic wait_count(input int unsigned tgt);
      int guard = 0;
      while (nbytes < tgt && guard < 5000) begin
         @(negedge clk);
         guard++;
      end
   endtask

   task automatic idle(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic summary;
      $display("  == %0d vectors applied, %0d miscompares ==", vec, bad);
      $finish;
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      bad++;
      $display("FAIL R7 watchdog expired actual=%0d expected=done", nbytes);
      summary();
   end

   initial begin
      logic [31:0] rd;
      int unsigned tgt, n1, k;
      void'($urandom(32'd2718));
      dlen[0] = 32'd8;  dlen[1] = 32'd5;  dlen[2] = 32'd12;
      dbuf[0] = 40'h00_2000_0000;
      dbuf[1] = 40'h00_2000_0100;
      dbuf[2] = 40'h03_0000_0040;
      err_addr = '1;
      pend = 1'b0; dly = 0; mem_gnt = 1'b0; mem_rvalid = 1'b0; mem_rerr = 1'b0;
      mem_rdata = '0; out_ready = 1'b0;
      reg_we = 1'b0; reg_addr = '0; reg_wdata = '0;
      rst_n = 1'b0;
      idle(5);
      check(!out_valid && !mem_req && !irq, "R1", "idle outputs in reset",
            {61'b0, out_valid, mem_req, irq}, 0);
      rst_n = 1'b1;
      reg_rd(4'd2, rd); check(rd == 0, "R1", "link position", rd, 0);
      reg_rd(4'd1, rd); check(rd == 0, "R1", "status", rd, 0);
      reg_rd(4'd0, rd); check(rd == 0, "R1", "control", rd, 0);

      reg_wr(4'd5, 32'h0000_00FF);
      reg_rd(4'd5, rd); check(rd == 32'h81, "R13", "low base readback", rd, 32'h81);
      reg_wr(4'd6, 32'h1);
      reg_wr(4'd3, 32'd25);
      reg_wr(4'd4, 32'd2);
      reg_wr(4'd7, 32'h1);
      reg_wr(4'd8, 32'd10);
      reg_wr(4'd0, 32'h00F0_0016);
      reg_rd(4'd0, rd); check(rd == 32'h00F0_0016, "R13", "control readback", rd, 32'h00F0_0016);

      wait_count(10);
      idle(40);
      check(nbytes == 10, "R5", "stall at limit", nbytes, 10);
      reg_rd(4'd2, rd); check(rd == 10, "R4", "link position at limit", rd, 10);
      reg_rd(4'd1, rd); check(rd == 32'h4, "R8", "completion after first buffer", rd, 32'h4);
      check(irq, "R11", "irq with completion enabled", 64'(irq), 1);
      reg_wr(4'd1, 32'h4);
      reg_rd(4'd1, rd); check(rd == 0, "R10", "completion cleared", rd, 0);
      check(!irq, "R11", "irq after clear", 64'(irq), 0);

      for (int it = 0; it < 10; it++) begin
         k = $urandom_range(1, 20);
         tgt = nbytes + k;
         reg_wr(4'd8, tgt % 25);
         wait_count(tgt);
         idle(40);
         check(nbytes == tgt, "R5", "random limit step", nbytes, tgt);
         reg_rd(4'd2, rd); check(rd == tgt % 25, "R4", "wrapped link position", rd, tgt % 25);
      end

      tgt = nbytes + 30;
      reg_wr(4'd7, 32'h0);
      wait_count(tgt);
      check(nbytes >= tgt, "R6", "limit ignored when disabled", nbytes, tgt);
      reg_wr(4'd0, 32'h00F0_0014);
      idle(60);
      n1 = nbytes;
      req_seen = 0;
      idle(60);
      check(nbytes == n1, "R7", "no bytes after run cleared", nbytes, n1);
      check(req_seen == 0, "R7", "no requests after run cleared", req_seen, 0);
      reg_rd(4'd2, rd); check(rd == n1 % 25, "R4", "position after stop", rd, n1 % 25);

      reg_wr(4'd8, (n1 + 17) % 25);
      reg_wr(4'd7, 32'h1);
      reg_wr(4'd0, 32'h00F0_0016);
      wait_count(n1 + 17);
      idle(40);
      check(nbytes == n1 + 17, "R7", "resume from stopped position", nbytes, n1 + 17);

      reg_wr(4'd0, 32'h1);
      idle(3);
      reg_rd(4'd2, rd); check(rd == 0, "R12", "stream reset clears position", rd, 0);
      reg_rd(4'd1, rd); check(rd == 0, "R12", "stream reset clears status", rd, 0);
      check(!out_valid && !mem_req, "R12", "idle in stream reset",
            {62'b0, out_valid, mem_req}, 0);
      reg_wr(4'd0, 32'h0);
      idle(5);
      nbytes = 0;

      dlen[1] = 32'd0;
      reg_wr(4'd7, 32'h0);
      reg_wr(4'd0, 32'h00F0_0012);
      for (int g = 0; g < 400; g++) begin
         reg_rd(4'd1, rd);
         if (rd[4]) break;
      end
      idle(20);
      check(nbytes == 8, "R9", "bytes before zero-length descriptor", nbytes, 8);
      reg_rd(4'd1, rd); check(rd == 32'h14, "R9", "descriptor error and completion status", rd, 32'h14);
      reg_rd(4'd0, rd); check(rd[1] == 1'b0, "R9", "run cleared on error", 64'(rd[1]), 0);
      check(irq, "R11", "irq from descriptor error", 64'(irq), 1);
      reg_wr(4'd0, 32'h0);
      check(!irq, "R11", "irq masked by enable", 64'(irq), 0);
      reg_rd(4'd1, rd); check(rd == 32'h14, "R10", "status kept while masked", rd, 32'h14);

      dlen[1] = 32'd5;
      reg_wr(4'd0, 32'h1);
      reg_wr(4'd0, 32'h0);
      idle(5);
      nbytes = 0;
      err_addr = 40'h00_2000_0104;
      reg_wr(4'd0, 32'h00F0_0012);
      for (int g = 0; g < 400; g++) begin
         reg_rd(4'd1, rd);
         if (rd[4]) break;
      end
      idle(20);
      check(nbytes == 12, "R9", "bytes before read error", nbytes, 12);
      reg_rd(4'd1, rd); check(rd[4] == 1'b1, "R9", "error response status", 64'(rd[4]), 1);
      reg_rd(4'd0, rd); check(rd[1] == 1'b0, "R9", "run cleared on read error", 64'(rd[1]), 0);

      summary();
   end

endmodule